// File: doc/BRIEF.md
# Periodic ADC Conversion Scheduler

This block paces an external analog-to-digital converter. A free-running period counter fires a start pulse every programmed number of system clock cycles. A one-cycle done pulse from the converter marks each finished conversion. Between the two pulses the block holds a busy flag. When the conversion ends it sets a sticky data-ready flag and can raise an interrupt.

The block also gives the converter a clock-enable strobe at a selectable fraction of the system clock. It drives the enable for the analog section's power, and by default that power is on only around each conversion. A separate output enables the reference buffer.

Software reaches the block through a small write port with two targets, a configuration byte and a rate word. Both are always visible on read-back outputs. A strobe on a separate input tells the block that the conversion result was read.

Top module: `adc_sched_ctrl`

## Requirements
- R1: After reset the configuration read-back is 0x00 and the rate read-back is 0x013F. The start, interrupt, power and reference-buffer outputs are all low.
- R2: While the enable bit (configuration bit 0) is set, a rate value N places start pulses N+1 system cycles apart, provided no conversion is still busy. While the enable bit is clear, no start pulse is issued.
- R3: A rate write (`wr_sel`=1) takes effect at once. The period counter reloads, so the next start comes N+1 cycles after the write cycle.
- R4: The busy flag (read-back bit 6) rises in the cycle after a start pulse and falls in the cycle after the converter's done pulse. A period that expires while busy produces no start. Clearing the enable bit drops busy.
- R5: The data-ready flag (read-back bit 7) is set on the cycle after a done pulse that ends a busy conversion. It clears when a configuration write has bit 7 at 1, or when `res_rd` is pulsed. If a completion and a clear arrive in the same cycle, the completion wins.
- R6: `irq` is high exactly when data-ready is set and the interrupt-enable bit (bit 1) is set.
- R7: The divider field (bits 5:4) sets the pace of `adc_clk_en`. Code 00 pulses every cycle, 01 every 2nd cycle and 10 every 4th cycle. The reserved code 11 behaves like 00. The strobe is aligned to a free-running cycle counter that starts at 0 after reset.
- R8: `ana_pwr_en` is low while the block is disabled. With the keep-on bit (bit 3) set, it is high for as long as the block is enabled. Otherwise it is high while busy, and also while the period counter is at or below two ADC-clock periods (2 × divide ratio system cycles) before the start.
- R9: `ref_buf_en` follows the reference-buffer bit (bit 2) of the configuration.
- R10: A done pulse that arrives while not busy is ignored. It changes neither the busy flag nor the data-ready flag.
- R11: Configuration writes store bits 0 to 5 as written, and the divider read-back keeps the code exactly as written, including 11. Bits 6 and 7 of the read-back show busy and data-ready and cannot be written directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 rate |
| wr_data | input | 16 | Write data (configuration uses bits 7:0) |
| res_rd | input | 1 | Result-read strobe, clears data-ready |
| adc_done | input | 1 | Conversion-finished pulse from the converter |
| cfg_rd | output | 8 | Configuration read-back with busy and data-ready |
| rate_rd | output | 16 | Rate read-back |
| adc_start | output | 1 | Conversion start pulse |
| adc_clk_en | output | 1 | ADC clock-enable strobe |
| ana_pwr_en | output | 1 | Analog section power enable |
| ref_buf_en | output | 1 | Reference buffer enable |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Some properties are checked on every cycle. A start never occurs while the block is disabled, it always has analog power, and it is always followed by busy. Busy and data-ready only rise after a start or an accepted done. The interrupt never fires without its enable. The strobe runs every cycle under codes 00 and 11. The exact N+1 spacing, the reload on a rate write, dropped periods under long conversions, the power lead window under each divider code, and the clear-versus-set priority of data-ready can only be shown by the bench's scenarios, which compare against a cycle model.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int CFG_W    = 8;
  localparam int B_EN     = 0;
  localparam int B_IEN    = 1;
  localparam int B_REF    = 2;
  localparam int B_KEEP   = 3;
  localparam int B_DIV_LO = 4;
  localparam int B_BUSY   = 6;
  localparam int B_RDY    = 7;

  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_2   = 2'b01,
    DIV_4   = 2'b10,
    DIV_RSV = 2'b11
  } div_code_e;

  typedef struct packed {
    div_code_e div;
    logic      keep;
    logic      refb;
    logic      ien;
    logic      en;
  } cfg_t;

  // reserved code falls back to the undivided rate
  function automatic logic [2:0] div_ratio(div_code_e code);
    case (code)
      DIV_2:   return 3'd2;
      DIV_4:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter logic [RATE_W-1:0] RATE_RST = 'h013F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [RATE_W-1:0] wr_data,
  input  logic              res_rd,
  input  logic              start,
  input  logic              done,
  output cfg_t              cfg,
  output logic [RATE_W-1:0] rate,
  output logic              rate_wr,
  output logic              busy,
  output logic              ready
);
  cfg_t              cfg_q, cfg_d;
  logic [RATE_W-1:0] rate_q;
  logic              busy_q, busy_d;
  logic              rdy_q, rdy_d;
  logic              cfg_wr, accept;

  always_comb begin
    cfg_wr  = wr_en && !wr_sel;
    rate_wr = wr_en && wr_sel;
    accept  = busy_q && done;

    cfg_d      = cfg_q;
    cfg_d.en   = wr_data[B_EN];
    cfg_d.ien  = wr_data[B_IEN];
    cfg_d.refb = wr_data[B_REF];
    cfg_d.keep = wr_data[B_KEEP];
    cfg_d.div  = div_code_e'(wr_data[B_DIV_LO +: 2]);

    busy_d = busy_q;
    if (accept)        busy_d = 1'b0;
    else if (!cfg_q.en) busy_d = 1'b0;
    else if (start)    busy_d = 1'b1;

    rdy_d = rdy_q;
    if (accept)                                rdy_d = 1'b1;
    else if (res_rd || (cfg_wr && wr_data[B_RDY])) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      rate_q <= RATE_RST;
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      if (cfg_wr)  cfg_q  <= cfg_d;
      if (rate_wr) rate_q <= wr_data;
      busy_q <= busy_d;
      rdy_q  <= rdy_d;
    end
  end

  assign cfg   = cfg_q;
  assign rate  = rate_q;
  assign busy  = busy_q;
  assign ready = rdy_q;
endmodule

// File: rtl/adc_period_timer.sv
module adc_period_timer #(
  parameter int RATE_W = 16,
  parameter logic [RATE_W-1:0] RATE_RST = 'h013F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              busy,
  input  logic [RATE_W-1:0] rate,
  input  logic              load,
  input  logic [RATE_W-1:0] load_val,
  input  logic [RATE_W-1:0] lead,
  output logic              start,
  output logic              near
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              zero;

  always_comb begin
    zero = (cnt_q == '0);
    if (load)      cnt_d = load_val;
    else if (!en)  cnt_d = rate;
    else if (zero) cnt_d = rate;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RATE_RST;
    else        cnt_q <= cnt_d;
  end

  assign start = en && zero && !busy;
  assign near  = (cnt_q <= lead);
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_ctl_pkg::*;
#(
  parameter int MAX_RATIO = 4,
  localparam int CW = $clog2(MAX_RATIO)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  div_code_e code,
  output logic [2:0] ratio,
  output logic      clk_en
);
  logic [CW-1:0] phase_q;
  logic [CW-1:0] mask;

  always_comb begin
    ratio  = div_ratio(code);
    mask   = CW'(ratio - 3'd1);
    clk_en = ((phase_q & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/adc_sched_ctrl.sv
module adc_sched_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter logic [RATE_W-1:0] RATE_RST = 'h013F,
  parameter int LEAD_ADC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [RATE_W-1:0] wr_data,
  input  logic              res_rd,
  input  logic              adc_done,
  output logic [CFG_W-1:0]  cfg_rd,
  output logic [RATE_W-1:0] rate_rd,
  output logic              adc_start,
  output logic              adc_clk_en,
  output logic              ana_pwr_en,
  output logic              ref_buf_en,
  output logic              irq
);
  cfg_t              cfg;
  logic [RATE_W-1:0] rate;
  logic              rate_wr, busy, ready, near;
  logic [2:0]        ratio;
  logic [RATE_W-1:0] lead;

  adc_ctl_regs #(.RATE_W(RATE_W), .RATE_RST(RATE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .res_rd(res_rd), .start(adc_start), .done(adc_done),
    .cfg(cfg), .rate(rate), .rate_wr(rate_wr), .busy(busy), .ready(ready)
  );

  adc_clk_div #(.MAX_RATIO(4)) u_div (
    .clk(clk), .rst_n(rst_n), .code(cfg.div), .ratio(ratio), .clk_en(adc_clk_en)
  );

  assign lead = RATE_W'(LEAD_ADC_CYC * int'(ratio));

  adc_period_timer #(.RATE_W(RATE_W), .RATE_RST(RATE_RST)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .busy(busy), .rate(rate),
    .load(rate_wr), .load_val(wr_data), .lead(lead),
    .start(adc_start), .near(near)
  );

  always_comb begin
    cfg_rd                    = '0;
    cfg_rd[B_EN]              = cfg.en;
    cfg_rd[B_IEN]             = cfg.ien;
    cfg_rd[B_REF]             = cfg.refb;
    cfg_rd[B_KEEP]            = cfg.keep;
    cfg_rd[B_DIV_LO +: 2]     = cfg.div;
    cfg_rd[B_BUSY]            = busy;
    cfg_rd[B_RDY]             = ready;
  end

  assign rate_rd    = rate;
  assign ana_pwr_en = cfg.en && (cfg.keep || busy || near);
  assign ref_buf_en = cfg.refb;
  assign irq        = ready && cfg.ien;
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk
  import adc_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             adc_done,
  input logic [CFG_W-1:0] cfg_rd,
  input logic             adc_start,
  input logic             adc_clk_en,
  input logic             ana_pwr_en,
  input logic             irq
);
  assert_no_start_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd[B_EN] |-> !adc_start);

  assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> cfg_rd[B_BUSY]);

  assert_busy_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rd[B_BUSY]) |-> $past(adc_start));

  assert_ready_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rd[B_RDY]) |-> ($past(adc_done) && $past(cfg_rd[B_BUSY])));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_rd[B_IEN] && cfg_rd[B_RDY]));

  assert_fast_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd[B_DIV_LO +: 2] == 2'b00 || cfg_rd[B_DIV_LO +: 2] == 2'b11) |-> adc_clk_en);

  assert_power_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ana_pwr_en);

  assert_power_off_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd[B_EN] |-> !ana_pwr_en);

  assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && !cfg_rd[B_BUSY] && !cfg_rd[B_RDY]) |=> !cfg_rd[B_RDY]);
endmodule

bind adc_sched_ctrl adc_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .adc_done(adc_done), .cfg_rd(cfg_rd),
  .adc_start(adc_start), .adc_clk_en(adc_clk_en), .ana_pwr_en(ana_pwr_en), .irq(irq)
);

// File: tb/test_adc_sched_ctrl.sv
module test_adc_sched_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr_en, wr_sel, res_rd, adc_done;
  logic [15:0] wr_data;
  logic [7:0]  cfg_rd;
  logic [15:0] rate_rd;
  logic        adc_start, adc_clk_en, ana_pwr_en, ref_buf_en, irq;

  adc_sched_ctrl i_adc_sched_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .res_rd(res_rd), .adc_done(adc_done), .cfg_rd(cfg_rd), .rate_rd(rate_rd),
    .adc_start(adc_start), .adc_clk_en(adc_clk_en), .ana_pwr_en(ana_pwr_en),
    .ref_buf_en(ref_buf_en), .irq(irq)
  );

  int  m_rate, m_cnt, m_dcnt, m_div;
  bit  m_en, m_ien, m_ref, m_keep, m_busy, m_rdy;
  int  total, bad, cyc, pend, lat, last_start, exp_gap, n_start;
  bit  resp_on, man_done, finished;

  function automatic int ratio();
    if (m_div == 1) return 2;
    if (m_div == 2) return 4;
    return 1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    int d = ratio();
    chk("R2", "adc_start", adc_start, int'(m_en && m_cnt == 0 && !m_busy));
    chk("R3", "rate_rd", rate_rd, m_rate);
    chk("R4", "busy", cfg_rd[6], m_busy);
    chk("R5", "ready", cfg_rd[7], m_rdy);
    chk("R6", "irq", irq, int'(m_rdy && m_ien));
    chk("R7", "adc_clk_en", adc_clk_en, int'((m_dcnt % d) == 0));
    chk("R8", "ana_pwr_en", ana_pwr_en, int'(m_en && (m_keep || m_busy || m_cnt <= 2 * d)));
    chk("R9", "ref_buf_en", ref_buf_en, m_ref);
    chk("R11", "cfg bits", cfg_rd[5:0], m_div * 16 + m_keep * 8 + m_ref * 4 + m_ien * 2 + m_en);
  endtask

  task automatic tick();
    bit st, acc, cw, rw;
    int n_cnt;
    bit n_busy, n_rdy;
    adc_done = man_done || (resp_on && pend == 1);
    if (pend > 0) pend--;
    st = m_en && m_cnt == 0 && !m_busy;
    if (resp_on && st) pend = lat;
    if (st) begin
      if (last_start >= 0 && exp_gap > 0) chk("R2", "start spacing", cyc - last_start, exp_gap);
      last_start = cyc;
      n_start++;
    end
    acc = m_busy && adc_done;
    cw  = wr_en && !wr_sel;
    rw  = wr_en && wr_sel;
    n_cnt  = rw ? int'(wr_data) : (!m_en || m_cnt == 0) ? m_rate : m_cnt - 1;
    n_busy = acc ? 1'b0 : !m_en ? 1'b0 : st ? 1'b1 : m_busy;
    n_rdy  = acc ? 1'b1 : (res_rd || (cw && wr_data[7])) ? 1'b0 : m_rdy;
    @(posedge clk);
    m_cnt = n_cnt; m_busy = n_busy; m_rdy = n_rdy;
    if (cw) begin
      m_en = wr_data[0]; m_ien = wr_data[1]; m_ref = wr_data[2];
      m_keep = wr_data[3]; m_div = int'(wr_data[5:4]);
    end
    if (rw) m_rate = int'(wr_data);
    m_dcnt = (m_dcnt + 1) % 4;
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(bit sel, int data);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    int base;
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; res_rd = 0; adc_done = 0;
    m_rate = 'h13F; m_cnt = 'h13F; m_dcnt = 0; m_div = 0;
    m_en = 0; m_ien = 0; m_ref = 0; m_keep = 0; m_busy = 0; m_rdy = 0;
    pend = 0; lat = 3; resp_on = 0; man_done = 0; last_start = -1; exp_gap = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cfg_rd reset", cfg_rd, 0);
    chk("R1", "rate_rd reset", rate_rd, 'h13F);
    chk("R1", "outputs reset", {adc_start, irq, ana_pwr_en, ref_buf_en}, 0);
    rst_n = 1'b1;

    // R2: idle while disabled
    base = n_start; run(20);
    chk("R2", "no start while disabled", n_start - base, 0);

    // R2/R7: period 10, divide by 2, interrupt on
    wr(1, 9);
    resp_on = 1; lat = 3; exp_gap = 10; last_start = -1;
    wr(0, 'h13);
    base = n_start; run(60);
    chk("R2", "start count period 10", int'(n_start - base >= 5), 1);

    // R5: W1C clear with fields rewritten, then result-read clear
    wr(0, 'h93);
    run(7);
    res_rd = 1'b1; tick(); res_rd = 1'b0;
    run(10);

    // R4: long conversion drops periods
    lat = 15; exp_gap = 0;
    base = n_start; run(80);
    chk("R4", "starts under long conversion", n_start - base, 4);
    run(20);
    resp_on = 0; run(20);

    // R10: done while idle is ignored
    wr(0, 'h02);
    run(4);
    res_rd = 1'b1; tick(); res_rd = 1'b0;
    man_done = 1'b1; tick(); man_done = 1'b0;
    tick();
    chk("R10", "ready after idle done", cfg_rd[7], 0);
    chk("R10", "busy after idle done", cfg_rd[6], 0);

    // R8/R9: keep-on, reference buffer, divide by 4, R3 rate write
    resp_on = 1; lat = 2;
    wr(0, 'h2D);
    run(15);
    last_start = cyc; exp_gap = 31;
    wr(1, 30);
    run(100);

    // R8 auto shutdown under divide by 4, then R7 reserved code
    wr(0, 'h21); run(70);
    wr(0, 'h31); run(40);

    // R3: mid-count rate write gives the next start 5 cycles later
    wr(1, 200); run(30);
    last_start = cyc; exp_gap = 5;
    wr(1, 4);
    run(40);

    // R5: completion and clear in the same cycle, completion wins
    lat = 3; exp_gap = 0;
    wr(1, 12); run(40);
    while (!(pend == 1)) tick();
    res_rd = 1'b1; tick(); res_rd = 1'b0;
    chk("R5", "set wins over clear", cfg_rd[7], 1);
    run(20);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule